// File: doc/BRIEF.md
# Power-Good Qualification Timer

This block produces the power-good signal of a multi-rail supply. It takes digitized undervoltage flags for each output rail, one undervoltage flag for the input line (bulk) sense, a remote-off request and a bias-ready flag. All four kinds of input are treated as asynchronous and pass through two-flop synchronizers. A cycle counter takes the place of an external timing capacitor. Power-good is raised only once every watched condition has stayed clear for a programmed number of clock cycles.

Power-good falls as soon as any blocking condition is seen. A blocking condition is any rail undervoltage, a line undervoltage, an active remote-off request or missing bias. A blocking condition also discharges the timer to zero, so the full delay starts again once all conditions clear. Overvoltage is handled elsewhere and has no input here. The delay length comes from the `delay_cycles` input. It is captured only while some blocking condition holds, so a value changed during qualification applies to the next start-up. A typical setting is 25,000,000 cycles, which is 200 ms at 125 MHz.

Top module: `pgood_qual`

## Requirements
- R1: On the clock edge where reset is sampled high, `pgood` goes low and the timer clears. After reset is released, `pgood` stays low until a full qualification has completed.
- R2: Asserting any bit of `rail_uv` (1 = rail under voltage) drives `pgood` low on the third rising edge after the change. `pgood` is still high after the second edge.
- R3: Asserting `line_uv` (1 = bulk sense below threshold) drives `pgood` low on the third rising edge after the change.
- R4: Asserting `off_req` (1 = shut down requested) drives `pgood` low on the third rising edge. Releasing `off_req` starts a fresh qualification from zero.
- R5: While `bias_ok` is 0, `pgood` is held low and the timer is held cleared, whatever the other inputs are.
- R6: When the last blocking condition clears and the captured delay is D, `pgood` is low after D+2 rising edges, is high after D+3 rising edges, and then stays high while no condition returns.
- R7: A blocking condition lasting only one clock cycle, seen partway through a qualification, restarts the delay from zero. `pgood` then rises D+3 edges after that condition clears.
- R8: `delay_cycles` is captured only while a blocking condition holds. Changing it during a qualification does not alter that qualification's length.
- R9: With a captured delay of 0, `pgood` rises on the third rising edge after the last condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_uv | input | NUM_RAILS | Per-rail undervoltage flags, asynchronous, 1 = under voltage |
| line_uv | input | 1 | Input-line undervoltage flag, asynchronous, 1 = below threshold |
| off_req | input | 1 | Remote-off request, asynchronous, 1 = off |
| bias_ok | input | 1 | Bias/reference ready, asynchronous, 1 = ready |
| delay_cycles | input | CNT_W | Qualification length in clock cycles |
| pgood | output | 1 | Registered power-good output |

## Verification
The hardest case to reach from the ports is a disturbance that arrives while a qualification is partway through. Here `pgood` stays low across the disturbance, so only the timing of the later rise shows whether the count restarted. The bench runs a short delay partway through and injects a single-cycle rail flag. It then checks that `pgood` is still low at the edge where the interrupted count would have finished, and that it rises exactly D+3 edges after the pulse ends. Capture of the delay value is checked the same way. `delay_cycles` is changed in the middle of a count, and the bench confirms that only the next start-up uses the new length.

// File: rtl/pgood_qual_pkg.sv
package pgood_qual_pkg;
  // Control flags carried through the synchronizer alongside the rail flags
  typedef struct packed {
    logic line_uv;
    logic off_req;
    logic bias_ok;
  } ctl_flags_t;

  localparam int unsigned CTL_W = $bits(ctl_flags_t);

  function automatic logic ctl_blocks(ctl_flags_t f);
    return f.line_uv | f.off_req | ~f.bias_ok;
  endfunction
endpackage

// File: rtl/pgood_sync.sv
module pgood_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  // reset value of 0 leaves bias_ok low, which counts as blocking
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else if (s == 0) stg[s] <= d_async;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pgood_timer.sv
module pgood_timer #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned DEF_DELAY = 25_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] delay_in,
  output logic             done
);
  localparam logic [CNT_W-1:0] DEF_LIM = CNT_W'(DEF_DELAY);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= DEF_LIM;
    end else if (clr) begin
      cnt <= '0;
      lim <= delay_in;   // R8: length captured only while blocked
    end else if (cnt != lim) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == lim);

  // R7: a blocking cycle discharges the timer
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  // R6: counting advances by one per clear cycle until the limit
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt != lim) |=> (cnt == $past(cnt) + 1'b1));
  // R6: count never passes the captured limit
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);
  // R8: limit is frozen during qualification
  p_lim_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (lim == $past(lim)));
endmodule

// File: rtl/pgood_qual.sv
module pgood_qual
  import pgood_qual_pkg::*;
#(
  parameter int unsigned NUM_RAILS = 4,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned DEF_DELAY = 25_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RAILS-1:0] rail_uv,
  input  logic                 line_uv,
  input  logic                 off_req,
  input  logic                 bias_ok,
  input  logic [CNT_W-1:0]     delay_cycles,
  output logic                 pgood
);
  localparam int unsigned SYNC_W = NUM_RAILS + CTL_W;

  ctl_flags_t           ctl_raw, ctl_s;
  logic [NUM_RAILS-1:0] rail_s;
  logic [SYNC_W-1:0]    sync_q;
  logic                 blocked;
  logic                 tmr_done;

  assign ctl_raw = '{line_uv: line_uv, off_req: off_req, bias_ok: bias_ok};

  pgood_sync #(.W(SYNC_W), .STAGES(2)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({rail_uv, ctl_raw}),
    .q_sync  (sync_q)
  );

  assign {rail_s, ctl_s} = sync_q;
  assign blocked = (|rail_s) | ctl_blocks(ctl_s);

  pgood_timer #(.CNT_W(CNT_W), .DEF_DELAY(DEF_DELAY)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (blocked),
    .delay_in (delay_cycles),
    .done     (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) pgood <= 1'b0;
    else     pgood <= !blocked && tmr_done;
  end

  // R2 R3 R4 R5: any synchronized blocking condition forces pgood low next edge
  p_block_drop_r2: assert property (@(posedge clk) disable iff (rst)
    blocked |=> !pgood);
  // R6: a rise only follows a completed count
  p_rise_after_count_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood) |-> $past(tmr_done));
  // R1: output is low in the cycle after reset
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !pgood);
endmodule

// File: tb/test_pgood_qual.sv
module test_pgood_qual;
  localparam int NR = 4;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [NR-1:0] rail_uv;
  logic          line_uv, off_req, bias_ok;
  logic [CW-1:0] delay_cycles;
  logic          pgood;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  pgood_qual #(.NUM_RAILS(NR), .CNT_W(CW), .DEF_DELAY(1000)) i_pgood_qual (
    .clk(clk), .rst(rst), .rail_uv(rail_uv), .line_uv(line_uv),
    .off_req(off_req), .bias_ok(bias_ok), .delay_cycles(delay_cycles),
    .pgood(pgood)
  );

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pgood=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // n rising edges, then settle at the falling edge
  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic all_clear();
    rail_uv = '0; line_uv = 0; off_req = 0; bias_ok = 1;
  endtask

  // After clearing all conditions, expect rise exactly d+3 edges later
  task automatic expect_rise(string req, int d);
    edges(d + 2);
    check(req, pgood, 1'b0);
    edges(1);
    check(req, pgood, 1'b1);
  endtask

  task automatic t_reset();
    rst = 1; rail_uv = '0; line_uv = 0; off_req = 0; bias_ok = 0;
    delay_cycles = 10;
    edges(3);
    check("R1", pgood, 1'b0);
    rst = 0;
    edges(5);
    check("R1", pgood, 1'b0);
  endtask

  task automatic t_bias_hold();
    rail_uv = '0; line_uv = 0; off_req = 0; bias_ok = 0;
    edges(40);
    check("R5", pgood, 1'b0);
    bias_ok = 1;
    expect_rise("R6", 10);
    edges(30);
    check("R6", pgood, 1'b1);
  endtask

  task automatic t_rail_drop();
    for (int i = 0; i < NR; i++) begin
      rail_uv[i] = 1'b1;
      edges(2);
      check("R2", pgood, 1'b1);
      edges(1);
      check("R2", pgood, 1'b0);
      rail_uv[i] = 1'b0;
      expect_rise("R6", 10);
    end
  endtask

  task automatic t_line_drop();
    line_uv = 1;
    edges(2);
    check("R3", pgood, 1'b1);
    edges(1);
    check("R3", pgood, 1'b0);
    edges(20);
    check("R3", pgood, 1'b0);
    line_uv = 0;
    expect_rise("R3", 10);
  endtask

  task automatic t_off();
    off_req = 1;
    edges(3);
    check("R4", pgood, 1'b0);
    edges(30);
    check("R4", pgood, 1'b0);
    off_req = 0;
    expect_rise("R4", 10);
  endtask

  task automatic t_glitch_restart();
    off_req = 1; edges(5); off_req = 0;
    edges(6);                 // partway into a 10-cycle count
    rail_uv[2] = 1; edges(1); rail_uv[2] = 0;
    edges(6);                 // uninterrupted count would have finished
    check("R7", pgood, 1'b0);
    edges(5 - 6 + 6);         // total 10+2 edges... realigned below
    // after the pulse cleared: 6+5 = 11 edges elapsed, need 12 low, 13 high
    edges(1);
    check("R7", pgood, 1'b0);
    edges(1);
    check("R7", pgood, 1'b1);
  endtask

  task automatic t_capture();
    off_req = 1; edges(5); off_req = 0;
    edges(2);
    delay_cycles = 3;         // change during count must be ignored
    expect_rise("R8", 10 - 2);
    edges(10);
    check("R8", pgood, 1'b1);
    off_req = 1; edges(5); off_req = 0;   // now 3 is captured
    expect_rise("R8", 3);
  endtask

  task automatic t_zero();
    delay_cycles = 0;
    line_uv = 1; edges(5); line_uv = 0;
    edges(2);
    check("R9", pgood, 1'b0);
    edges(1);
    check("R9", pgood, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_bias_hold();
    t_rail_drop();
    t_line_drop();
    t_off();
    t_glitch_restart();
    t_capture();
    t_zero();
    all_clear();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule